// File: doc/BRIEF.md
# Sticky Event Record Log

A device-local log of error and device events (memory faults as well as health or environmental changes) that system software reaches through a command/response port. Hardware producers push events into an append port; each stored event receives a unique 16-bit handle and keeps its event type and address. The storage is a circular buffer that reports occupancy-limited reads and tracks events it had to throw away.

Software retrieves events in two steps: a Get command returns a batch of records, oldest first, without removing anything, and a later Clear command names the oldest record by its handle together with a count, and removes that many records. Commands and hardware appends never interleave inside a record: an event that arrives while a command is in progress waits in a one-entry staging register and is stored once the command ends. The log contents, handle counter and overflow state are touched only by a dedicated power-on reset; the warm reset, which stands for hot and function-level resets, returns only the command controller to idle.

Top module: `evlog_top`

## Requirements
- R1: After power-on reset the log is empty: a Get answers with a single response carrying status EMPTY (2), `rsp_last` high, overflow 0 and dropped count 0.
- R2: A Get accepted at a clock edge yields min(count, occupancy) responses on consecutive cycles starting the cycle after acceptance, oldest record first, status OK (0), with `rsp_last` high on the final one; a count of 0 or an empty log gives one EMPTY response.
- R3: A Get removes nothing: an identical Get issued afterwards returns the same records.
- R4: Stored records receive handles in storage order, starting at 1 and increasing by 1, skipping 0 when the 16-bit counter wraps.
- R5: A Clear whose handle equals the oldest record's handle and whose count is between 1 and the occupancy removes that many oldest records and answers OK in the cycle after acceptance; any other Clear answers INVALID (1) and removes nothing. The response echoes the supplied handle.
- R6: An append arriving while a command is in progress is staged and stored after the command finishes, so it is absent from that command's response; an append that finds the staging register already occupied is discarded and counted as dropped.
- R7: An append that finds the log full is discarded; the overflow flag is set and stays set, the dropped count increments (saturating), and both are reported with every response.
- R8: The warm reset returns the controller to idle (`cmd_ready` high) and leaves records, handles, overflow and dropped count unchanged.
- R9: The power-on reset empties the log, clears overflow and dropped count, and restarts handles at 1.
- R10: `cmd_ready` is high only while no command is in progress; it is low in every cycle carrying a response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-on reset, active low; initializes the log |
| warm_rst_n | input | 1 | Warm reset, active low; resets the command controller only |
| app_valid | input | 1 | Append request |
| app_type | input | TYPE_W | Event type of the appended record |
| app_addr | input | ADDR_W | Address of the appended record |
| cmd_valid | input | 1 | Command request, taken when `cmd_ready` is high |
| cmd_ready | output | 1 | Controller idle, command can be accepted |
| cmd_op | input | 1 | 0 = Get, 1 = Clear |
| cmd_count | input | CNT_W | Get: maximum records; Clear: records to remove |
| cmd_handle | input | 16 | Clear: handle of the oldest record |
| rsp_valid | output | 1 | Response beat valid |
| rsp_last | output | 1 | Final beat of the response |
| rsp_status | output | 2 | 0 OK, 1 INVALID, 2 EMPTY |
| rsp_handle | output | 16 | Record handle (Get) or echoed handle (Clear) |
| rsp_type | output | TYPE_W | Record event type (Get) |
| rsp_addr | output | ADDR_W | Record address (Get) |
| rsp_overflow | output | 1 | Sticky overflow flag |
| rsp_dropped | output | DROP_W | Saturating count of discarded events |

## Verification
Every response beat is due exactly one cycle after the edge that accepted its command, and Get beats follow back to back, so the bench drives on the falling edge, lets the rising edge accept, and samples each beat on the next falling edges. A direct append is stored at the first rising edge it is held across; a staged one is stored one edge after the command's last beat, so every follow-up Get is issued only after that edge. The dropped count from a staging collision changes at the edge closing the final beat, so the bench expects the old count during the beats and the new count on the next Get.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

  localparam int HANDLE_W = 16;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_BADH  = 2'd1,
    ST_EMPTY = 2'd2
  } evlog_status_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_GET  = 2'd1,
    CS_CLR  = 2'd2
  } evlog_state_e;

  // Next handle in allocation order; 0 is never produced.
  function automatic logic [HANDLE_W-1:0] handle_after(input logic [HANDLE_W-1:0] h);
    return (h == {HANDLE_W{1'b1}}) ? HANDLE_W'(1) : h + HANDLE_W'(1);
  endfunction

  // Number of records a read request actually returns.
  function automatic int unsigned batch_len(input int unsigned want, input int unsigned have);
    return (want < have) ? want : have;
  endfunction

endpackage

// File: rtl/evlog_store.sv
module evlog_store
  import evlog_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 32,
  parameter int DROP_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                wr_en,
  input  logic [TYPE_W-1:0]   wr_type,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                drop_in,
  input  logic                pop_en,
  input  logic [CNT_W-1:0]    pop_cnt,
  input  logic [CNT_W-1:0]    rd_idx,
  output logic [HANDLE_W-1:0] rd_handle,
  output logic [TYPE_W-1:0]   rd_type,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]    occ,
  output logic [HANDLE_W-1:0] head_handle,
  output logic                ovf,
  output logic [DROP_W-1:0]   dropped,
  output logic                wr_stored,
  output logic [HANDLE_W-1:0] wr_handle
);

  logic [HANDLE_W-1:0] hmem [DEPTH];
  logic [TYPE_W-1:0]   tmem [DEPTH];
  logic [ADDR_W-1:0]   amem [DEPTH];

  logic [PTR_W-1:0]    head;
  logic [PTR_W-1:0]    tail;
  logic [PTR_W-1:0]    rd_slot;
  logic [HANDLE_W-1:0] next_h;
  logic                full;
  logic                lose;

  assign full      = (occ == CNT_W'(DEPTH));
  assign tail      = head + occ[PTR_W-1:0];
  assign rd_slot   = head + rd_idx[PTR_W-1:0];
  assign wr_stored = wr_en && !full;
  assign wr_handle = next_h;
  assign lose      = drop_in || (wr_en && full);

  assign rd_handle   = hmem[rd_slot];
  assign rd_type     = tmem[rd_slot];
  assign rd_addr     = amem[rd_slot];
  assign head_handle = hmem[head];

  // Record storage: no reset of any kind touches it.
  always_ff @(posedge clk) begin
    if (wr_stored) begin
      hmem[tail] <= next_h;
      tmem[tail] <= wr_type;
      amem[tail] <= wr_addr;
    end
  end

  // Pointers and bookkeeping: initialized by the power-on reset only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      head    <= '0;
      occ     <= '0;
      next_h  <= HANDLE_W'(1);
      ovf     <= 1'b0;
      dropped <= '0;
    end else begin
      if (wr_stored) next_h <= handle_after(next_h);
      if (pop_en) head <= head + pop_cnt[PTR_W-1:0];
      occ <= occ + CNT_W'(wr_stored) - (pop_en ? pop_cnt : CNT_W'(0));
      if (lose) begin
        ovf <= 1'b1;
        if (dropped != {DROP_W{1'b1}}) dropped <= dropped + DROP_W'(1);
      end
    end
  end

endmodule

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
  import evlog_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_op,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic [HANDLE_W-1:0] cmd_handle,
  input  logic                app_valid,
  input  logic [TYPE_W-1:0]   app_type,
  input  logic [ADDR_W-1:0]   app_addr,
  input  logic [CNT_W-1:0]    occ,
  input  logic [HANDLE_W-1:0] head_handle,
  input  logic [HANDLE_W-1:0] rd_handle,
  input  logic [TYPE_W-1:0]   rd_type,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]    rd_idx,
  output logic                wr_en,
  output logic [TYPE_W-1:0]   wr_type,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic                drop_out,
  output logic                pop_en,
  output logic [CNT_W-1:0]    pop_cnt,
  output logic                busy,
  output logic                rsp_valid,
  output logic                rsp_last,
  output logic [1:0]          rsp_status,
  output logic [HANDLE_W-1:0] rsp_handle,
  output logic [TYPE_W-1:0]   rsp_type,
  output logic [ADDR_W-1:0]   rsp_addr
);

  evlog_state_e        state;
  logic [CNT_W-1:0]    idx;
  logic [CNT_W-1:0]    n_lat;
  logic [CNT_W-1:0]    clr_cnt;
  logic [HANDLE_W-1:0] clr_handle;
  logic                stage_vld;
  logic [TYPE_W-1:0]   stage_type;
  logic [ADDR_W-1:0]   stage_addr;
  logic                idle;
  logic                get_last;
  logic                clr_ok;

  assign idle      = (state == CS_IDLE);
  assign busy      = !idle;
  assign cmd_ready = idle;
  assign get_last  = (n_lat == '0) || (idx == n_lat - CNT_W'(1));
  assign clr_ok    = (clr_handle == head_handle) && (clr_cnt != '0) && (clr_cnt <= occ);
  assign rd_idx    = idx;

  // Commit path: staged event first, then a fresh one, only while idle.
  assign wr_en    = idle && (stage_vld || app_valid);
  assign wr_type  = stage_vld ? stage_type : app_type;
  assign wr_addr  = stage_vld ? stage_addr : app_addr;
  assign drop_out = busy && app_valid && stage_vld;
  assign pop_en   = (state == CS_CLR) && clr_ok;
  assign pop_cnt  = clr_cnt;

  always_comb begin
    rsp_valid  = 1'b0;
    rsp_last   = 1'b0;
    rsp_status = ST_OK;
    rsp_handle = '0;
    rsp_type   = '0;
    rsp_addr   = '0;
    case (state)
      CS_GET: begin
        rsp_valid = 1'b1;
        rsp_last  = get_last;
        if (n_lat == '0) begin
          rsp_status = ST_EMPTY;
        end else begin
          rsp_handle = rd_handle;
          rsp_type   = rd_type;
          rsp_addr   = rd_addr;
        end
      end
      CS_CLR: begin
        rsp_valid  = 1'b1;
        rsp_last   = 1'b1;
        rsp_status = clr_ok ? ST_OK : ST_BADH;
        rsp_handle = clr_handle;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= CS_IDLE;
      idx        <= '0;
      n_lat      <= '0;
      clr_cnt    <= '0;
      clr_handle <= '0;
      stage_vld  <= 1'b0;
      stage_type <= '0;
      stage_addr <= '0;
    end else begin
      // staging register
      if (idle) begin
        if (stage_vld && app_valid) begin
          stage_type <= app_type;
          stage_addr <= app_addr;
        end else if (stage_vld) begin
          stage_vld <= 1'b0;
        end
      end else if (app_valid && !stage_vld) begin
        stage_vld  <= 1'b1;
        stage_type <= app_type;
        stage_addr <= app_addr;
      end
      // command sequencing
      case (state)
        CS_IDLE: if (cmd_valid) begin
          if (cmd_op) begin
            clr_handle <= cmd_handle;
            clr_cnt    <= cmd_count;
            state      <= CS_CLR;
          end else begin
            n_lat <= CNT_W'(batch_len(int'(cmd_count), int'(occ)));
            idx   <= '0;
            state <= CS_GET;
          end
        end
        CS_GET: begin
          if (get_last) state <= CS_IDLE;
          else          idx   <= idx + CNT_W'(1);
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evlog_top.sv
module evlog_top
  import evlog_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 32,
  parameter int DROP_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                warm_rst_n,
  input  logic                app_valid,
  input  logic [TYPE_W-1:0]   app_type,
  input  logic [ADDR_W-1:0]   app_addr,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_op,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic [HANDLE_W-1:0] cmd_handle,
  output logic                rsp_valid,
  output logic                rsp_last,
  output logic [1:0]          rsp_status,
  output logic [HANDLE_W-1:0] rsp_handle,
  output logic [TYPE_W-1:0]   rsp_type,
  output logic [ADDR_W-1:0]   rsp_addr,
  output logic                rsp_overflow,
  output logic [DROP_W-1:0]   rsp_dropped
);

  logic                ctrl_rst_n;
  logic                wr_en;
  logic [TYPE_W-1:0]   wr_type;
  logic [ADDR_W-1:0]   wr_addr;
  logic                drop_ev;
  logic                pop_en;
  logic [CNT_W-1:0]    pop_cnt;
  logic [CNT_W-1:0]    rd_idx;
  logic [HANDLE_W-1:0] rd_handle;
  logic [TYPE_W-1:0]   rd_type;
  logic [ADDR_W-1:0]   rd_addr;
  logic [CNT_W-1:0]    occ;
  logic [HANDLE_W-1:0] head_handle;
  logic                wr_stored;
  logic [HANDLE_W-1:0] wr_handle;
  logic                busy;

  assign ctrl_rst_n = por_n && warm_rst_n;

  evlog_store #(
    .DEPTH(DEPTH), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .DROP_W(DROP_W)
  ) u_store (
    .clk(clk), .por_n(por_n),
    .wr_en(wr_en), .wr_type(wr_type), .wr_addr(wr_addr),
    .drop_in(drop_ev), .pop_en(pop_en), .pop_cnt(pop_cnt),
    .rd_idx(rd_idx), .rd_handle(rd_handle), .rd_type(rd_type), .rd_addr(rd_addr),
    .occ(occ), .head_handle(head_handle),
    .ovf(rsp_overflow), .dropped(rsp_dropped),
    .wr_stored(wr_stored), .wr_handle(wr_handle)
  );

  evlog_ctrl #(
    .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(ctrl_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .cmd_handle(cmd_handle),
    .app_valid(app_valid), .app_type(app_type), .app_addr(app_addr),
    .occ(occ), .head_handle(head_handle),
    .rd_handle(rd_handle), .rd_type(rd_type), .rd_addr(rd_addr), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_type(wr_type), .wr_addr(wr_addr),
    .drop_out(drop_ev), .pop_en(pop_en), .pop_cnt(pop_cnt), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_status(rsp_status),
    .rsp_handle(rsp_handle), .rsp_type(rsp_type), .rsp_addr(rsp_addr)
  );

endmodule

// File: rtl/evlog_chk.sv
module evlog_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             por_n,
  input logic             warm_rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             rsp_valid,
  input logic             rsp_last,
  input logic             wr_stored,
  input logic [15:0]      wr_handle,
  input logic             busy,
  input logic             pop_en,
  input logic [CNT_W-1:0] pop_cnt,
  input logic [CNT_W-1:0] occ,
  input logic             ovf
);

  // R2
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    cmd_valid && cmd_ready |=> rsp_valid);

  // R2
  last_valid_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    rsp_last |-> rsp_valid);

  // R10
  ready_excl_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    rsp_valid |-> !cmd_ready);

  // R4
  handle_nz_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_stored |-> wr_handle != 16'd0);

  // R5
  pop_bound_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    pop_en |-> (pop_cnt != '0) && (pop_cnt <= occ));

  // R6
  commit_idle_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    wr_stored |-> !busy);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    ovf |=> ovf);

endmodule

bind evlog_top evlog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_last(rsp_last),
  .wr_stored(wr_stored), .wr_handle(wr_handle), .busy(busy),
  .pop_en(pop_en), .pop_cnt(pop_cnt), .occ(occ), .ovf(rsp_overflow)
);

// File: tb/tb_evlog_top.sv
module tb_evlog_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int TYPE_W = 4;
  localparam int ADDR_W = 32;
  localparam int DROP_W = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              por_n = 1'b0;
  logic              warm_rst_n = 1'b0;
  logic              app_valid = 1'b0;
  logic [TYPE_W-1:0] app_type = '0;
  logic [ADDR_W-1:0] app_addr = '0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic              cmd_op = 1'b0;
  logic [CNT_W-1:0]  cmd_count = '0;
  logic [15:0]       cmd_handle = '0;
  logic              rsp_valid, rsp_last, rsp_overflow;
  logic [1:0]        rsp_status;
  logic [15:0]       rsp_handle;
  logic [TYPE_W-1:0] rsp_type;
  logic [ADDR_W-1:0] rsp_addr;
  logic [DROP_W-1:0] rsp_dropped;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evlog_top #(.DEPTH(DEPTH), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .DROP_W(DROP_W)) dut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .app_valid(app_valid), .app_type(app_type), .app_addr(app_addr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .cmd_handle(cmd_handle),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_status(rsp_status),
    .rsp_handle(rsp_handle), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
    .rsp_overflow(rsp_overflow), .rsp_dropped(rsp_dropped)
  );

  // Payload derived from a tag so the bench can predict each record.
  function automatic logic [TYPE_W-1:0] tag_type(input int t);
    return TYPE_W'(t % (1 << TYPE_W));
  endfunction
  function automatic logic [ADDR_W-1:0] tag_addr(input int t);
    return ADDR_W'(32'h4000_0000 + t * 64);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int t);
    @(negedge clk);
    app_valid = 1'b1; app_type = tag_type(t); app_addr = tag_addr(t);
    @(negedge clk);
    app_valid = 1'b0;
  endtask

  // One beat of a Get response, sampled at a falling edge.
  task automatic beat(input string req, input int h, input bit last, input bit ovf, input int drp);
    chk(req, "valid", rsp_valid, 1);
    chk(req, "status", rsp_status, 0);
    chk(req, "handle", rsp_handle, h);
    chk(req, "type", rsp_type, tag_type(h));
    chk(req, "addr", rsp_addr, tag_addr(h));
    chk(req, "last", rsp_last, last);
    chk(req, "overflow", rsp_overflow, ovf);
    chk(req, "dropped", rsp_dropped, drp);
    chk("R10", "ready low in response", cmd_ready, 0);
  endtask

  task automatic get(input string req, input int cnt, input int n, input int h0, input bit ovf, input int drp);
    @(negedge clk);
    chk("R10", "ready idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_count = CNT_W'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (n == 0) begin
      chk(req, "valid", rsp_valid, 1);
      chk(req, "status EMPTY", rsp_status, 2);
      chk(req, "last", rsp_last, 1);
      chk(req, "overflow", rsp_overflow, ovf);
      chk(req, "dropped", rsp_dropped, drp);
    end else begin
      for (int i = 0; i < n; i++) begin
        beat(req, h0 + i, i == n - 1, ovf, drp);
        if (i < n - 1) @(negedge clk);
      end
    end
  endtask

  task automatic clear(input string req, input int h, input int cnt, input int exp_st);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_count = CNT_W'(cnt); cmd_handle = 16'(h);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(req, "clr valid", rsp_valid, 1);
    chk(req, "clr status", rsp_status, exp_st);
    chk(req, "clr handle echo", rsp_handle, h);
    chk(req, "clr last", rsp_last, 1);
  endtask

  task automatic t_reset_state;
    get("R1", 4, 0, 0, 0, 0);
  endtask

  task automatic t_get_basic;
    push(1); push(2); push(3);
    get("R2", 8, 3, 1, 0, 0);    // R4 handles 1,2,3
    get("R3", 8, 3, 1, 0, 0);    // nothing removed by previous Get
    get("R2", 2, 2, 1, 0, 0);    // count smaller than occupancy
    get("R2", 0, 0, 0, 0, 0);    // count zero gives EMPTY
  endtask

  task automatic t_clear;
    clear("R5", 2, 1, 1);        // not oldest
    clear("R5", 1, 0, 1);        // count zero
    clear("R5", 1, 4, 1);        // more than stored
    get("R5", 8, 3, 1, 0, 0);    // nothing removed
    clear("R5", 1, 2, 0);
    get("R5", 8, 1, 3, 0, 0);
  endtask

  task automatic t_staging;
    push(4);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_count = CNT_W'(2);
    @(negedge clk);              // first beat
    cmd_valid = 1'b0;
    beat("R6", 3, 0, 0, 0);
    app_valid = 1'b1; app_type = tag_type(5); app_addr = tag_addr(5);
    @(negedge clk);              // second beat, staging holds tag 5
    beat("R6", 4, 1, 0, 0);
    app_type = tag_type(99); app_addr = tag_addr(99);
    @(negedge clk);              // tag 99 hit occupied staging
    app_valid = 1'b0;
    @(negedge clk);
    get("R6", 8, 3, 3, 1, 1);
  endtask

  task automatic t_warm;
    @(negedge clk);
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
    chk("R8", "ready after warm reset", cmd_ready, 1);
    get("R8", 8, 3, 3, 1, 1);
  endtask

  task automatic t_full;
    for (int t = 6; t <= 10; t++) push(t);
    push(11);                    // log full, discarded
    get("R7", 8, 8, 3, 1, 2);
    clear("R7", 3, 8, 0);
    get("R7", 8, 0, 0, 1, 2);
  endtask

  task automatic t_por;
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    get("R9", 8, 0, 0, 0, 0);
    push(1);
    get("R9", 8, 1, 1, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    warm_rst_n = 1'b1;
    t_reset_state();
    t_get_basic();
    t_clear();
    t_staging();
    t_warm();
    t_full();
    t_por();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule